// File: doc/BRIEF.md
# Transmit Fabric Width Adapter

This block sits between user transmit logic and a transmit datapath that is fixed at two bytes wide. User logic presents a word of two or four bytes, plus two control bits per byte, on the rising edge of its own clock. The adapter turns that word into a stream of internal words, each carrying two byte lanes, on the internal clock. Its output goes to a downstream line encoder or, when encoding is bypassed, straight to the serializing logic.

Two static settings select the behaviour. One is a two-bit width code for the user side: 16, 20, 32 or 40 bits. The other says whether line encoding is on. With encoding on, only the 20 and 40 codes are legal. User logic then supplies 16 or 32 data bits, and the adapter passes one marker bit per byte to the encoder. With encoding bypassed, the 20 and 40 codes widen every byte into a 10-bit symbol by adding that byte's two control bits. The 16 and 32 codes pass raw bytes through.

The four-byte codes expect the user clock at half the internal rate, and each user word leaves as two internal words. The two-byte codes expect both clocks at the same rate. An illegal setting raises an error flag and holds the output at zero.

Top module: `tx_fabric_width_adapt`

## Requirements
- R1: The width code on `cfg_width` is 2'b00 = 16, 2'b01 = 20, 2'b10 = 32 and 2'b11 = 40 bits. When `cfg_enc_en` is 1 together with code 2'b00 or 2'b10, `cfg_err` is 1 and `int_data` and `int_mark` stay at zero. For every legal setting, `cfg_err` is 0.
- R2: While `rst_n` is low, and after its release until the first captured word has been presented, `int_data` and `int_mark` are zero.
- R3: User inputs are captured on the rising edge of `usr_clk`. With codes 2'b00 and 2'b01, each user word gives exactly one internal word built from byte lanes 0 and 1. Lane 0 is `usr_data[7:0]`, and lane i uses bit i of each control input. Lanes 2 and 3 and their control bits have no effect.
- R4: With codes 2'b10 and 2'b11, each user word gives two internal words on consecutive internal cycles. The first carries user lanes 0 and 1 and the second carries user lanes 2 and 3.
- R5: The half-select phase is on the lower half at the first internal edge after reset release and toggles on every internal clock edge. Each assertion of reset brings it back to the lower half.
- R6: With encoding bypassed and code 2'b01 or 2'b11, each internal lane becomes a 10-bit symbol {ctl_a bit, ctl_b bit, data byte}, with the A bit as the most significant bit. Internal lane 0 occupies `int_data[9:0]` and lane 1 occupies `int_data[19:10]`.
- R7: With encoding bypassed and code 2'b00 or 2'b10, `int_data[15:0]` is {lane 1 byte, lane 0 byte} and `int_data[19:16]` is zero.
- R8: With encoding on and code 2'b01 or 2'b11, `int_data[15:0]` is {lane 1 byte, lane 0 byte}, `int_data[19:16]` is zero, and `int_mark[i]` is the ctl_a bit of internal lane i.
- R9: `int_mark` is zero whenever encoding is bypassed.
- R10: A captured word reaches `int_data` at the first internal rising edge after the user edge that captured it, through a single output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| usr_clk | input | 1 | User-side clock; rising edge captures user inputs |
| int_clk | input | 1 | Internal datapath clock |
| cfg_enc_en | input | 1 | 1 = downstream line encoding on |
| cfg_width | input | 2 | User width code (see R1) |
| usr_data | input | 32 | Four user data bytes, lane 0 in the low byte |
| usr_ctl_a | input | 4 | Per-byte control bit A (marker or symbol MSB) |
| usr_ctl_b | input | 4 | Per-byte control bit B (symbol bit 8) |
| int_data | output | 20 | Internal word of two lanes |
| int_mark | output | 2 | Per-lane marker for the line encoder |
| cfg_err | output | 1 | Illegal width and encoding setting |

## Verification
The riskiest corner is the order of the halves. A design that swaps them, or that takes its half-select phase out of step after a reset, sends lanes 2 and 3 first. The first check after each reset in the wide modes catches this. In the two-byte modes, random data in the unused upper lanes would leak into the output if the lane select ignored the width code. In the symbol modes, constant all-ones and all-zero words and random control bits expose a swapped A/B position or lane-1 symbol placement. The two illegal settings are held for several cycles with live data, so a design that forgets to blank its output shows nonzero words.

// File: rtl/tx_wa_pkg.sv
package tx_wa_pkg;

   typedef enum logic [1:0] {
      WCODE_16 = 2'b00,
      WCODE_20 = 2'b01,
      WCODE_32 = 2'b10,
      WCODE_40 = 2'b11
   } wcode_e;

   // four-byte user words need two internal words each
   function automatic logic code_is_wide(input logic [1:0] code);
      return (code == WCODE_32) || (code == WCODE_40);
   endfunction

   // codes that carry 10 bits per byte on the user side
   function automatic logic code_has_ext(input logic [1:0] code);
      return (code == WCODE_20) || (code == WCODE_40);
   endfunction

endpackage

// File: rtl/tx_wa_capture.sv
module tx_wa_capture #(
   parameter int BYTE_W    = 8,
   parameter int USR_LANES = 4
) (
   input  logic                              usr_clk,
   input  logic                              rst_n,
   input  logic [USR_LANES*BYTE_W-1:0]       in_data,
   input  logic [USR_LANES-1:0]              in_ctl_a,
   input  logic [USR_LANES-1:0]              in_ctl_b,
   output logic [USR_LANES-1:0][BYTE_W-1:0]  cap_byte,
   output logic [USR_LANES-1:0]              cap_a,
   output logic [USR_LANES-1:0]              cap_b
);

   logic [USR_LANES-1:0][BYTE_W-1:0] lane_in;

   for (genvar l = 0; l < USR_LANES; l++) begin : g_split
      assign lane_in[l] = in_data[l*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge usr_clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_byte <= '0;
         cap_a    <= '0;
         cap_b    <= '0;
      end else begin
         cap_byte <= lane_in;
         cap_a    <= in_ctl_a;
         cap_b    <= in_ctl_b;
      end
   end

endmodule

// File: rtl/tx_wa_phase.sv
module tx_wa_phase (
   input  logic int_clk,
   input  logic rst_n,
   output logic phase
);

   always_ff @(posedge int_clk or negedge rst_n) begin
      if (!rst_n) phase <= 1'b0;
      else        phase <= ~phase;
   end

endmodule

// File: rtl/tx_wa_lane.sv
module tx_wa_lane #(
   parameter int BYTE_W    = 8,
   parameter int USR_LANES = 4,
   parameter int INT_LANES = 2,
   parameter int LANE      = 0,
   localparam int SYM_W    = BYTE_W + 2
) (
   input  logic [USR_LANES-1:0][BYTE_W-1:0] cap_byte,
   input  logic [USR_LANES-1:0]             cap_a,
   input  logic [USR_LANES-1:0]             cap_b,
   input  logic                             sel_hi,
   output logic [BYTE_W-1:0]                lane_byte,
   output logic                             lane_a,
   output logic [SYM_W-1:0]                 lane_sym
);

   localparam int LO_IDX = LANE;
   localparam int HI_IDX = INT_LANES + LANE;

   logic lane_b;

   always_comb begin
      if (sel_hi) begin
         lane_byte = cap_byte[HI_IDX];
         lane_a    = cap_a[HI_IDX];
         lane_b    = cap_b[HI_IDX];
      end else begin
         lane_byte = cap_byte[LO_IDX];
         lane_a    = cap_a[LO_IDX];
         lane_b    = cap_b[LO_IDX];
      end
      lane_sym = {lane_a, lane_b, lane_byte};
   end

endmodule

// File: rtl/tx_fabric_width_adapt.sv
module tx_fabric_width_adapt
   import tx_wa_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int USR_LANES = 4,
   parameter int INT_LANES = 2
) (
   input  logic                          rst_n,
   input  logic                          usr_clk,
   input  logic                          int_clk,
   input  logic                          cfg_enc_en,
   input  logic [1:0]                    cfg_width,
   input  logic [USR_LANES*BYTE_W-1:0]   usr_data,
   input  logic [USR_LANES-1:0]          usr_ctl_a,
   input  logic [USR_LANES-1:0]          usr_ctl_b,
   output logic [INT_LANES*(BYTE_W+2)-1:0] int_data,
   output logic [INT_LANES-1:0]          int_mark,
   output logic                          cfg_err
);

   localparam int SYM_W  = BYTE_W + 2;
   localparam int INT_DW = INT_LANES * SYM_W;
   localparam int NAR_DW = INT_LANES * BYTE_W;
   localparam int PAD_W  = INT_DW - NAR_DW;

   if (USR_LANES != 2 * INT_LANES) begin : g_bad_lanes
      $error("user lane count must be twice the internal lane count");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("byte width must be at least one bit");
   end

   logic [USR_LANES-1:0][BYTE_W-1:0] cap_byte;
   logic [USR_LANES-1:0]             cap_a;
   logic [USR_LANES-1:0]             cap_b;
   logic                             phase;
   logic                             wide;
   logic                             ext;
   logic                             sel_hi;
   logic                             err_c;
   logic [INT_DW-1:0]                sym_word;
   logic [NAR_DW-1:0]                nar_word;
   logic [INT_LANES-1:0]             lane_a;
   logic [INT_DW-1:0]                data_n;
   logic [INT_LANES-1:0]             mark_n;

   tx_wa_capture #(
      .BYTE_W    (BYTE_W),
      .USR_LANES (USR_LANES)
   ) i_capture (
      .usr_clk  (usr_clk),
      .rst_n    (rst_n),
      .in_data  (usr_data),
      .in_ctl_a (usr_ctl_a),
      .in_ctl_b (usr_ctl_b),
      .cap_byte (cap_byte),
      .cap_a    (cap_a),
      .cap_b    (cap_b)
   );

   tx_wa_phase i_phase (
      .int_clk (int_clk),
      .rst_n   (rst_n),
      .phase   (phase)
   );

   assign wide    = code_is_wide(cfg_width);
   assign ext     = code_has_ext(cfg_width);
   assign err_c   = cfg_enc_en & ~ext;
   assign sel_hi  = wide & phase;
   assign cfg_err = err_c;

   for (genvar i = 0; i < INT_LANES; i++) begin : g_lane
      logic [BYTE_W-1:0] l_byte;
      logic [SYM_W-1:0]  l_sym;

      tx_wa_lane #(
         .BYTE_W    (BYTE_W),
         .USR_LANES (USR_LANES),
         .INT_LANES (INT_LANES),
         .LANE      (i)
      ) i_lane (
         .cap_byte  (cap_byte),
         .cap_a     (cap_a),
         .cap_b     (cap_b),
         .sel_hi    (sel_hi),
         .lane_byte (l_byte),
         .lane_a    (lane_a[i]),
         .lane_sym  (l_sym)
      );

      assign sym_word[i*SYM_W +: SYM_W]   = l_sym;
      assign nar_word[i*BYTE_W +: BYTE_W] = l_byte;
   end

   always_comb begin
      data_n = '0;
      mark_n = '0;
      if (!err_c) begin
         if (ext && !cfg_enc_en) data_n = sym_word;
         else                    data_n = {{PAD_W{1'b0}}, nar_word};
         if (cfg_enc_en)         mark_n = lane_a;
      end
   end

   always_ff @(posedge int_clk or negedge rst_n) begin
      if (!rst_n) begin
         int_data <= '0;
         int_mark <= '0;
      end else begin
         int_data <= data_n;
         int_mark <= mark_n;
      end
   end

endmodule

// File: rtl/tx_fabric_width_adapt_chk.sv
module tx_fabric_width_adapt_chk #(
   parameter int INT_DW    = 20,
   parameter int INT_LANES = 2,
   parameter int NAR_DW    = 16
) (
   input logic                 int_clk,
   input logic                 rst_n,
   input logic                 cfg_enc_en,
   input logic [1:0]           cfg_width,
   input logic                 cfg_err,
   input logic                 phase,
   input logic [INT_DW-1:0]    int_data,
   input logic [INT_LANES-1:0] int_mark
);

   logic past_ok;

   always_ff @(posedge int_clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R1: an illegal setting blanks the output
   assert_err_blank_R1: assert property (@(posedge int_clk) disable iff (!rst_n)
      cfg_err |=> (int_data == '0 && int_mark == '0));

   // R5: the half-select phase alternates each internal cycle
   assert_phase_toggle_R5: assert property (@(posedge int_clk) disable iff (!rst_n)
      past_ok |-> (phase != $past(phase)));

   // R7 and R8: no symbol extension means the pad bits stay at zero
   assert_pad_zero_R7: assert property (@(posedge int_clk) disable iff (!rst_n)
      !(cfg_width[0] && !cfg_enc_en) |-> (int_data[INT_DW-1:NAR_DW] == '0));

   // R9: the marker is silent when encoding is bypassed
   assert_mark_bypass_R9: assert property (@(posedge int_clk) disable iff (!rst_n)
      !cfg_enc_en |-> (int_mark == '0));

endmodule

bind tx_fabric_width_adapt tx_fabric_width_adapt_chk #(
   .INT_DW    (INT_LANES*(BYTE_W+2)),
   .INT_LANES (INT_LANES),
   .NAR_DW    (INT_LANES*BYTE_W)
) i_chk (
   .int_clk    (int_clk),
   .rst_n      (rst_n),
   .cfg_enc_en (cfg_enc_en),
   .cfg_width  (cfg_width),
   .cfg_err    (cfg_err),
   .phase      (phase),
   .int_data   (int_data),
   .int_mark   (int_mark)
);

// File: tb/test_tx_fabric_width_adapt.sv
module test_tx_fabric_width_adapt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        uclk_div = 1'b0;
   logic        usr_clk;
   logic        cfg_enc_en = 1'b0;
   logic [1:0]  cfg_width = 2'b00;
   logic [31:0] usr_data = '0;
   logic [3:0]  usr_ctl_a = '0;
   logic [3:0]  usr_ctl_b = '0;
   logic [19:0] int_data;
   logic [1:0]  int_mark;
   logic        cfg_err;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (run_en) uclk_div <= ~uclk_div;
      else        uclk_div <= 1'b0;
   end

   assign usr_clk = cfg_width[1] ? uclk_div : ~clk;

   tx_fabric_width_adapt i_tx_fabric_width_adapt (
      .rst_n      (rst_n),
      .usr_clk    (usr_clk),
      .int_clk    (clk),
      .cfg_enc_en (cfg_enc_en),
      .cfg_width  (cfg_width),
      .usr_data   (usr_data),
      .usr_ctl_a  (usr_ctl_a),
      .usr_ctl_b  (usr_ctl_b),
      .int_data   (int_data),
      .int_mark   (int_mark),
      .cfg_err    (cfg_err)
   );

   function automatic logic [21:0] expect_out(input logic [1:0] w, input logic enc,
                                              input logic [31:0] d, input logic [3:0] a,
                                              input logic [3:0] b, input int half);
      int lo;
      logic [7:0] b0, b1;
      lo = half * 2;
      b0 = d[lo*8 +: 8];
      b1 = d[(lo+1)*8 +: 8];
      if (enc && !w[0]) return '0;
      if (enc)          return {a[lo+1], a[lo], 4'b0, b1, b0};
      if (w[0])         return {2'b00, a[lo+1], b[lo+1], b1, a[lo], b[lo], b0};
      return {2'b00, 4'b0, b1, b0};
   endfunction

   task automatic check(input string tag, input logic [21:0] act, input logic [21:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] d, input logic [3:0] a, input logic [3:0] b);
      usr_data  = d;
      usr_ctl_a = a;
      usr_ctl_b = b;
   endtask

   task automatic run_cfg(input logic [1:0] w, input logic enc, input int nwords);
      logic [31:0] wd [0:63];
      logic [3:0]  wa [0:63];
      logic [3:0]  wb [0:63];
      string       tag;
      rst_n  = 1'b0;
      run_en = 1'b0;
      cfg_width  = w;
      cfg_enc_en = enc;
      for (int k = 0; k < 64; k++) begin
         wd[k] = $urandom;
         wa[k] = 4'($urandom);
         wb[k] = 4'($urandom);
      end
      wd[1] = 32'hFFFF_FFFF; wa[1] = 4'hF; wb[1] = 4'hF;
      wd[2] = 32'h0000_0000; wa[2] = 4'h0; wb[2] = 4'h0;
      wd[3] = 32'hA5C3_3C5A; wa[3] = 4'b1010; wb[3] = 4'b0101;
      drive(32'hDEAD_BEEF, 4'hF, 4'hF);
      repeat (3) @(posedge clk);
      #2;
      check("R2 reset output", {int_mark, int_data}, '0);
      check("R1 error flag", {21'b0, cfg_err}, {21'b0, enc && !w[0]});
      drive(wd[0], wa[0], wb[0]);
      rst_n  = 1'b1;
      run_en = 1'b1;
      for (int k = 0; k < nwords; k++) begin
         @(posedge clk);
         #2;
         if (enc && !w[0]) tag = "R1 blanked";
         else if (k == 0)  tag = "R5 R10 first lower half";
         else if (enc)     tag = "R8 encode word";
         else if (w[0])    tag = "R6 symbol word";
         else              tag = "R7 raw word";
         check(tag, {int_mark, int_data}, expect_out(w, enc, wd[k], wa[k], wb[k], 0));
         if (!w[1] && !(enc && !w[0]))
            check("R3 narrow uses lanes 0 1", {int_mark, int_data},
                  expect_out(w, enc, wd[k], wa[k], wb[k], 0));
         if (!enc) check("R9 mark idle", {20'b0, int_mark}, '0);
         drive(wd[k+1], wa[k+1], wb[k+1]);
         if (w[1]) begin
            @(posedge clk);
            #2;
            check(enc && !w[0] ? "R1 blanked" : "R4 upper half second",
                  {int_mark, int_data}, expect_out(w, enc, wd[k], wa[k], wb[k], 1));
         end
      end
      rst_n  = 1'b0;
      run_en = 1'b0;
      @(posedge clk);
      #2;
      check("R5 reset clears output", {int_mark, int_data}, '0);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h1357_9bdf));
      run_cfg(2'b00, 1'b0, 40);
      run_cfg(2'b01, 1'b0, 40);
      run_cfg(2'b10, 1'b0, 40);
      run_cfg(2'b11, 1'b0, 40);
      run_cfg(2'b01, 1'b1, 40);
      run_cfg(2'b11, 1'b1, 40);
      run_cfg(2'b00, 1'b1, 8);
      run_cfg(2'b10, 1'b1, 8);
      run_cfg(2'b11, 1'b0, 17);
      run_cfg(2'b10, 1'b1, 5);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule